// File: doc/BRIEF.md
# Protection Unit Configuration Register Bank

This block is the configuration store of a memory protection unit. A processor reaches it through a coprocessor-style access port. Each access carries a read/write flag, a 4-bit primary register number, a 3-bit selector, a 4-bit secondary register number and a 32-bit write word.

The bank holds the following registers:
- the control word;
- the data and instruction cacheable masks;
- the write-buffer mask;
- the data and instruction permission words, with four bits per region;
- the eight region base/size words.

Every stored value leaves the block on its own output, so the region checker can use it directly.

The permission words can be reached in two formats. In the compact format, each region has a 2-bit field; writes expand it and reads compress it. In the full format, each region has a 4-bit nibble and the word passes through unchanged. Reads are combinational. An access that names no implemented register is rejected. It raises a one-cycle error pulse, and a rejected read returns zero.

Top module: `mpu_cfg_bank`

## Requirements
- R1: After reset the control word `ctl_q` is 0x00000078, and every other stored word (cacheable masks, write-buffer mask, permission words, regions) is zero.
- R2: Primary 1 with selector 0 reads and writes the control word. Any other selector on primary 1 is invalid.
- R3: Primary 2 with selector 0 reads and writes the data cacheable mask, and with selector 1 the instruction cacheable mask. Selectors 2 to 7 are invalid.
- R4: Primary 3 reads and writes the write-buffer mask with any selector.
- R5: A compact write (primary 5, selector 0 for data, 1 for instruction) stores write bits [2k+1:2k] into permission bits [4k+1:4k] for k = 0..7. Bits [4k+3:4k+2] are cleared.
- R6: A compact read (primary 5, selector 0 data, 1 instruction) returns permission bits [4k+1:4k] in read bits [2k+1:2k]. Bits [31:16] read as zero.
- R7: Primary 5 with selector 2 (data) or 3 (instruction) reads and writes the full permission word unchanged. Selectors 4 to 7 are invalid.
- R8: Primary 6 addresses region word number `acc_sec`. Values 8 to 15 are invalid.
- R9: Primary 0 is read-only. Selector 0 returns the device ID parameter (default 0x41059461) and selector 1 the cache type parameter (default 0x0F004006). Other selectors and all writes are invalid.
- R10: Primaries 4, 12 and 14, and every primary number not named in R2 to R9, are invalid for reads and writes.
- R11: An invalid access raises `acc_err` in the cycle after its clock edge, for one cycle only, and changes no stored word. An invalid read returns zero on `rd_data`.
- R12: A valid read drives `rd_data` in the same cycle as the request, changes no stored word and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_pri | input | 4 | Primary register number |
| acc_sel | input | 3 | Selector |
| acc_sec | input | 4 | Secondary register number |
| acc_wdata | input | 32 | Write word |
| rd_data | output | 32 | Combinational read word, zero when no valid read |
| acc_err | output | 1 | One-cycle pulse after an invalid access |
| ctl_q | output | 32 | Control word |
| dcache_q | output | 32 | Data cacheable mask |
| icache_q | output | 32 | Instruction cacheable mask |
| wbuf_q | output | 32 | Write-buffer mask |
| dperm_q | output | 32 | Data permission word, 4 bits per region |
| iperm_q | output | 32 | Instruction permission word, 4 bits per region |
| region_q | output | 256 | Region words, region n in bits [32n+31:32n] |

## Verification
Every stored word drives an output directly. A corrupted register therefore shows up on that output at the clock edge that corrupts it. It would be seen at the next sample, before any read-back is needed.

A wrong format conversion or a misdecoded selector shows up in two ways:
- as a wrong nibble layout on the permission outputs one cycle after the write;
- as a wrong `rd_data` in the cycle of the read.

A decoder that accepts an invalid access shows up as a missing `acc_err` pulse one cycle later, or as a changed stored word.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_ID, RS_CTYPE, RS_CTL, RS_DC, RS_IC, RS_WB,
    RS_DP_PK, RS_IP_PK, RS_DP, RS_IP, RS_RGN
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrDc;
    logic   wrIc;
    logic   wrWb;
    logic   wrDp;
    logic   wrIp;
    logic   wrRgn;
    logic   legacy;
    logic [3:0] rgnIdx;
    rdSel_e rdSel;
    logic   bad;
  } strobes_t;

endpackage

// File: rtl/mpu_cfg_ctrl.sv
module mpu_cfg_ctrl
  import mpu_cfg_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [3:0] acc_pri,
  input  logic [2:0] acc_sel,
  input  logic [3:0] acc_sec,
  output strobes_t   st,
  output logic       acc_err
);

  localparam logic [4:0] RGN_LIM = 5'(NUM_REGIONS);

  always_comb begin
    st = '0;
    st.rdSel = RS_NONE;
    st.rgnIdx = acc_sec;
    if (acc_valid) begin
      unique case (acc_pri)
        4'd0: begin
          if (acc_write) st.bad = 1'b1;
          else if (acc_sel == 3'd0) st.rdSel = RS_ID;
          else if (acc_sel == 3'd1) st.rdSel = RS_CTYPE;
          else st.bad = 1'b1;
        end
        4'd1: begin
          if (acc_sel != 3'd0) st.bad = 1'b1;
          else if (acc_write) st.wrCtl = 1'b1;
          else st.rdSel = RS_CTL;
        end
        4'd2: begin
          if (acc_sel == 3'd0) begin
            if (acc_write) st.wrDc = 1'b1; else st.rdSel = RS_DC;
          end else if (acc_sel == 3'd1) begin
            if (acc_write) st.wrIc = 1'b1; else st.rdSel = RS_IC;
          end else st.bad = 1'b1;
        end
        4'd3: begin
          if (acc_write) st.wrWb = 1'b1; else st.rdSel = RS_WB;
        end
        4'd5: begin
          st.legacy = (acc_sel == 3'd0) || (acc_sel == 3'd1);
          unique case (acc_sel)
            3'd0: if (acc_write) st.wrDp = 1'b1; else st.rdSel = RS_DP_PK;
            3'd1: if (acc_write) st.wrIp = 1'b1; else st.rdSel = RS_IP_PK;
            3'd2: if (acc_write) st.wrDp = 1'b1; else st.rdSel = RS_DP;
            3'd3: if (acc_write) st.wrIp = 1'b1; else st.rdSel = RS_IP;
            default: st.bad = 1'b1;
          endcase
        end
        4'd6: begin
          if ({1'b0, acc_sec} >= RGN_LIM) st.bad = 1'b1;
          else if (acc_write) st.wrRgn = 1'b1;
          else st.rdSel = RS_RGN;
        end
        default: st.bad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= st.bad;
  end

  // R11: error pulse lasts exactly one cycle unless a new invalid access follows
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !st.bad) |=> !acc_err);

  // R10: reserved primary numbers are always rejected
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_pri == 4'd4 || acc_pri == 4'd12 || acc_pri == 4'd14)) |=> acc_err);

  // R8: out-of-range region number is rejected
  a_r8_region_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_pri == 4'd6 && acc_sec >= 4'd8) |=> acc_err);

endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_cfg_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          NUM_REGIONS = 8,
  parameter logic [31:0] DEVICE_ID   = 32'h4105_9461,
  parameter logic [31:0] CACHE_TYPE  = 32'h0F00_4006,
  parameter logic [31:0] CTL_RESET   = 32'h0000_0078
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobes_t                      st,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rd_data,
  output logic [DATA_W-1:0]             ctlQ,
  output logic [DATA_W-1:0]             dcQ,
  output logic [DATA_W-1:0]             icQ,
  output logic [DATA_W-1:0]             wbQ,
  output logic [DATA_W-1:0]             dpQ,
  output logic [DATA_W-1:0]             ipQ,
  output logic [NUM_REGIONS*DATA_W-1:0] rgnFlat
);

  localparam int PERM_W = 4 * NUM_REGIONS;
  localparam int PACK_W = 2 * NUM_REGIONS;

  logic [DATA_W-1:0] rgn [NUM_REGIONS];
  logic [DATA_W-1:0] wide;
  logic [DATA_W-1:0] dpPacked, ipPacked, permIn, rgnRd;

  always_comb begin
    wide = '0;
    dpPacked = '0;
    ipPacked = '0;
    for (int k = 0; k < NUM_REGIONS; k++) begin
      wide[4*k +: 2]     = wdata[2*k +: 2];
      dpPacked[2*k +: 2] = dpQ[4*k +: 2];
      ipPacked[2*k +: 2] = ipQ[4*k +: 2];
    end
  end

  assign permIn = st.legacy ? wide : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlQ <= CTL_RESET;
      dcQ  <= '0;
      icQ  <= '0;
      wbQ  <= '0;
      dpQ  <= '0;
      ipQ  <= '0;
    end else begin
      if (st.wrCtl) ctlQ <= wdata;
      if (st.wrDc)  dcQ  <= wdata;
      if (st.wrIc)  icQ  <= wdata;
      if (st.wrWb)  wbQ  <= wdata;
      if (st.wrDp)  dpQ  <= permIn;
      if (st.wrIp)  ipQ  <= permIn;
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (!rst_n) rgn[r] <= '0;
      else if (st.wrRgn && st.rgnIdx == 4'(r)) rgn[r] <= wdata;
    end
    assign rgnFlat[r*DATA_W +: DATA_W] = rgn[r];
  end

  always_comb begin
    rgnRd = '0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (st.rgnIdx == 4'(r)) rgnRd = rgn[r];
  end

  always_comb begin
    unique case (st.rdSel)
      RS_ID:    rd_data = DEVICE_ID;
      RS_CTYPE: rd_data = CACHE_TYPE;
      RS_CTL:   rd_data = ctlQ;
      RS_DC:    rd_data = dcQ;
      RS_IC:    rd_data = icQ;
      RS_WB:    rd_data = wbQ;
      RS_DP_PK: rd_data = dpPacked;
      RS_IP_PK: rd_data = ipPacked;
      RS_DP:    rd_data = dpQ;
      RS_IP:    rd_data = ipQ;
      RS_RGN:   rd_data = rgnRd;
      default:  rd_data = '0;
    endcase
  end

  // R5: a compact write never leaves an upper nibble pair set
  a_r5_compact_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wrDp && st.legacy) |=> ((dpQ[PERM_W-1:0] & {NUM_REGIONS{4'b1100}}) == '0));

  // R6: compact reads carry nothing above the packed fields
  a_r6_packed_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rdSel == RS_DP_PK || st.rdSel == RS_IP_PK) |-> (rd_data[DATA_W-1:PACK_W] == '0));

endmodule

// File: rtl/mpu_cfg_bank.sv
module mpu_cfg_bank
  import mpu_cfg_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          NUM_REGIONS = 8,
  parameter logic [31:0] DEVICE_ID   = 32'h4105_9461,
  parameter logic [31:0] CACHE_TYPE  = 32'h0F00_4006,
  parameter logic [31:0] CTL_RESET   = 32'h0000_0078
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic                          acc_write,
  input  logic [3:0]                    acc_pri,
  input  logic [2:0]                    acc_sel,
  input  logic [3:0]                    acc_sec,
  input  logic [DATA_W-1:0]             acc_wdata,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          acc_err,
  output logic [DATA_W-1:0]             ctl_q,
  output logic [DATA_W-1:0]             dcache_q,
  output logic [DATA_W-1:0]             icache_q,
  output logic [DATA_W-1:0]             wbuf_q,
  output logic [DATA_W-1:0]             dperm_q,
  output logic [DATA_W-1:0]             iperm_q,
  output logic [NUM_REGIONS*DATA_W-1:0] region_q
);

  strobes_t st;

  mpu_cfg_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_pri(acc_pri), .acc_sel(acc_sel), .acc_sec(acc_sec),
    .st(st), .acc_err(acc_err)
  );

  mpu_cfg_regs #(
    .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS), .DEVICE_ID(DEVICE_ID),
    .CACHE_TYPE(CACHE_TYPE), .CTL_RESET(CTL_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .st(st), .wdata(acc_wdata), .rd_data(rd_data),
    .ctlQ(ctl_q), .dcQ(dcache_q), .icQ(icache_q), .wbQ(wbuf_q),
    .dpQ(dperm_q), .ipQ(iperm_q), .rgnFlat(region_q)
  );

  // R11: a rejected access leaves every stored word unchanged
  a_r11_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ($stable(ctl_q) && $stable(dcache_q) && $stable(icache_q) &&
                 $stable(wbuf_q) && $stable(dperm_q) && $stable(iperm_q) &&
                 $stable(region_q)));

  // R12: a read changes no stored word
  a_r12_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> ($stable(ctl_q) && $stable(dperm_q) &&
                                   $stable(iperm_q) && $stable(region_q)));

endmodule

// File: tb/tb_mpu_cfg_bank.sv
module tb_mpu_cfg_bank;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]   acc_pri = '0, acc_sec = '0;
  logic [2:0]   acc_sel = '0;
  logic [31:0]  acc_wdata = '0;
  logic [31:0]  rd_data, ctl_q, dcache_q, icache_q, wbuf_q, dperm_q, iperm_q;
  logic         acc_err;
  logic [255:0] region_q;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [31:0] mCtl, mDc, mIc, mWb, mDp, mIp;
  logic [31:0] mRg [8];

  always #2.5 clk = ~clk;

  mpu_cfg_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_pri(acc_pri), .acc_sel(acc_sel), .acc_sec(acc_sec), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .acc_err(acc_err), .ctl_q(ctl_q), .dcache_q(dcache_q),
    .icache_q(icache_q), .wbuf_q(wbuf_q), .dperm_q(dperm_q), .iperm_q(iperm_q),
    .region_q(region_q)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) r[4*k +: 2] = v[2*k +: 2];
    return r;
  endfunction

  function automatic logic [31:0] compress(input logic [31:0] v);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) r[2*k +: 2] = v[4*k +: 2];
    return r;
  endfunction

  function automatic bit isValid(input bit wr, input int p, input int s, input int sc);
    case (p)
      0: return !wr && s < 2;
      1: return s == 0;
      2: return s < 2;
      3: return 1'b1;
      5: return s < 4;
      6: return sc < 8;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input int p, input int s, input int sc);
    if (!isValid(1'b0, p, s, sc)) return '0;
    case (p)
      0: return (s == 0) ? 32'h4105_9461 : 32'h0F00_4006;
      1: return mCtl;
      2: return (s == 0) ? mDc : mIc;
      3: return mWb;
      5: case (s)
           0: return compress(mDp);
           1: return compress(mIp);
           2: return mDp;
           default: return mIp;
         endcase
      default: return mRg[sc];
    endcase
  endfunction

  function automatic logic [255:0] rgFlat();
    logic [255:0] f;
    for (int r = 0; r < 8; r++) f[32*r +: 32] = mRg[r];
    return f;
  endfunction

  task automatic checkState(input string req);
    check(req, {ctl_q, dcache_q, icache_q, wbuf_q, dperm_q, iperm_q},
               {mCtl, mDc, mIc, mWb, mDp, mIp});
    check(req, region_q, rgFlat());
  endtask

  task automatic doWrite(input int p, input int s, input int sc, input logic [31:0] d, input string req);
    bit ok = isValid(1'b1, p, s, sc);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1;
    acc_pri = 4'(p); acc_sel = 3'(s); acc_sec = 4'(sc); acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    if (ok) begin
      case (p)
        1: mCtl = d;
        2: if (s == 0) mDc = d; else mIc = d;
        3: mWb = d;
        5: case (s)
             0: mDp = expand(d);
             1: mIp = expand(d);
             2: mDp = d;
             default: mIp = d;
           endcase
        6: mRg[sc] = d;
        default: ;
      endcase
    end
    check({req, " err"}, 256'(acc_err), 256'(!ok));
    checkState(req);
  endtask

  task automatic doRead(input int p, input int s, input int sc, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0;
    acc_pri = 4'(p); acc_sel = 3'(s); acc_sec = 4'(sc); acc_wdata = 32'hDEAD_BEEF;
    #1;
    check({req, " rd_data"}, 256'(rd_data), 256'(expRead(p, s, sc)));
    @(negedge clk);
    acc_valid = 1'b0;
    check({req, " err"}, 256'(acc_err), 256'(!isValid(1'b0, p, s, sc)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mCtl = 32'h78; mDc = '0; mIc = '0; mWb = '0; mDp = '0; mIp = '0;
    for (int r = 0; r < 8; r++) mRg[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkState("R1 reset");
    check("R1 err after reset", 256'(acc_err), 256'(0));

    // R5 / R6 / R7 explicit format cases
    doWrite(5, 2, 0, 32'hFFFF_FFFF, "R7 full data write");
    doRead(5, 0, 0, "R6 compact read of all-ones");
    doWrite(5, 0, 0, 32'hFFFF_FFFF, "R5 compact write clears upper bits");
    check("R5 dperm layout", 256'(dperm_q), 256'(32'h3333_3333));
    doWrite(5, 1, 0, 32'h0000_E4B1, "R5 compact instruction write");
    doRead(5, 3, 0, "R7 full instruction read");
    doRead(5, 1, 0, "R6 compact instruction read");

    // R11 one-cycle pulse then idle
    doWrite(4, 0, 0, 32'h1234_5678, "R11 reserved write");
    @(negedge clk);
    check("R11 err one cycle", 256'(acc_err), 256'(0));

    // Exhaustive write sweep over primary x selector, secondary follows selector
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 8; s++)
        doWrite(p, s, s, 32'h9E37_79B9 * 32'(p * 8 + s + 1), "R2-R10 write sweep");

    // Region bounds: secondary 8..15 rejected, 0..7 accepted
    for (int sc = 0; sc < 16; sc++)
      doWrite(6, sc % 8, sc, 32'hC0DE_0000 | 32'(sc), "R8 region write");

    // Exhaustive read sweep, then region read sweep
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 8; s++)
        doRead(p, s, 0, "R9 R10 R12 read sweep");
    for (int sc = 0; sc < 16; sc++)
      doRead(6, 3, sc, "R8 region read");

    doRead(1, 0, 0, "R2 control read");
    doRead(2, 1, 0, "R3 instruction cacheable read");
    doRead(3, 7, 0, "R4 write buffer any selector");
    doRead(0, 0, 0, "R9 device id");
    doRead(0, 1, 0, "R9 cache type");
    doRead(12, 0, 0, "R10 reserved 12");
    doRead(14, 0, 0, "R10 reserved 14");
    checkState("R12 state after reads");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule